// File: doc/BRIEF.md
# Return-Address Register Access Router

This block sits between the system-register access path of a core and two 64-bit exception return-address registers. One register belongs to privilege level 1 and the other to level 2. Each request carries the five-field accessor encoding, a read/write flag, the current privilege level, a 3-bit nested-virtualization control value, a host-mode flag and the lock-condition inputs. From these inputs the router decides whether the access:

- reaches the low (level-1) register,
- reaches the high (level-2) register,
- is redirected to a fixed memory offset, or
- ends as undefined, as a trap to level 2, or as a lock exception.

The router also holds both registers. An exception-entry port loads a return address into either register. A separate entry event covers an exception from a 32-bit level-2 context into a 64-bit level 3, and it adjusts the upper half of the high register. Each request gets exactly one registered result, one cycle after it is accepted.

Top module: `retaddr_access_router`

## Requirements
- R1: The high-register accessor is op0=3, op1=4, CRn=4, CRm=0, op2=1. The low-register accessor is the same except op1=0. Any other encoding gives result code 3 (undefined) and leaves both registers unchanged.
- R2: A request at level 0 gives result code 3 (undefined) for both accessors.
- R3: At level 1 the high accessor behaves as follows. A control value with bits 2 and 0 both set reaches the low register. Otherwise, if bit 0 is set, the result is code 4 (trap) with syndrome 0x18. Otherwise the result is code 3.
- R4: At level 1 the low accessor behaves as follows. Control 011 traps with code 4 and syndrome 0x18. Control 111 gives code 2 (memory redirect) with offset 0x230, and the direction flag equals the write flag. Every other value reaches the low register.
- R5: At levels 2 and 3 the high accessor always reaches the high register.
- R6: At level 2 the low accessor reaches the high register when host mode is set, and the low register otherwise. At level 3 it always reaches the low register.
- R7: A write gives code 5 (lock exception), ahead of every other outcome, when all four of these hold: the lock feature is present, lock is enabled, the core is not halted, and the lock bit is set. The cases it applies to are:
  - At level 2: the high accessor, and the low accessor in host mode only.
  - At level 1: the high accessor when control bit 0 is set, and the low accessor unless control bits 1 and 0 are both set.
  - Never at level 3.
- R8: A read of a register gives code 0 with the register contents. A write gives code 1, and a read in the next cycle returns the written value.
- R9: An exception-entry load writes the address into the low register (select 0) or the high register (select 1). If it hits the same register as a write in the same cycle, the load wins.
- R10: On the 32-bit-to-level-3 entry event, the upper 32 bits of the high register are cleared when UPPER_CLEAR is 1 and kept when it is 0. The lower 32 bits are kept in both cases.
- R11: The response valid signal rises exactly one cycle after each accepted request and is low otherwise, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Accessor field op0 |
| req_op1 | input | 3 | Accessor field op1 |
| req_crn | input | 4 | Accessor field CRn |
| req_crm | input | 4 | Accessor field CRm |
| req_op2 | input | 3 | Accessor field op2 |
| req_level | input | 2 | Current privilege level 0..3 |
| req_nv | input | 3 | Nested-virtualization control value |
| req_host | input | 1 | Host mode active |
| req_wdata | input | 64 | Write data |
| lock_feat | input | 1 | Lock feature present |
| lock_en | input | 1 | Lock enabled |
| core_halted | input | 1 | Core in halted debug state |
| lock_bit | input | 1 | Current lock bit |
| exc_valid | input | 1 | Exception-entry load |
| exc_to_high | input | 1 | Load target: 0 low, 1 high register |
| exc_addr | input | 64 | Return address to load |
| narrow_entry | input | 1 | 32-bit level-2 context entering 64-bit level 3 |
| rsp_valid | output | 1 | Result valid |
| rsp_code | output | 3 | 0 read, 1 write done, 2 memory, 3 undefined, 4 trap, 5 lock |
| rsp_rdata | output | 64 | Read data (code 0 only) |
| rsp_mem_offset | output | 12 | Redirect offset (code 2 only) |
| rsp_mem_write | output | 1 | Redirect direction, 1 = write |
| rsp_syndrome | output | 6 | Trap syndrome (code 4 only) |

## Verification
The hardest case is a collision on the same storage in one cycle. An exception-entry load and a write to the same register arrive together, and only a later read can show which one won. The bench drives both in one request cycle and then reads at level 3, where the route is unconditional. The lock cases are also hard to reach. They need all four lock inputs set together with a write, so the vector table arms them as one flag. A directed case then clears only the halted condition and shows that the write goes through.

// File: rtl/retaddr_rt_pkg.sv
// Package: shared result codes, storage targets and accessor layout for the
// return-address access router. Assumes a 64-bit register file width.
package retaddr_rt_pkg;

    typedef enum logic [2:0] {
        RSP_RDATA  = 3'd0,
        RSP_WDONE  = 3'd1,
        RSP_MEMFWD = 3'd2,
        RSP_UNDEF  = 3'd3,
        RSP_TRAP   = 3'd4,
        RSP_LOCK   = 3'd5
    } rsp_code_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_LOW  = 2'd1,
        TGT_HIGH = 2'd2
    } tgt_e;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysenc_t;

    localparam sysenc_t ENC_HIGH = '{op0: 2'b11, op1: 3'b100, crn: 4'b0100, crm: 4'b0000, op2: 3'b001};
    localparam sysenc_t ENC_LOW  = '{op0: 2'b11, op1: 3'b000, crn: 4'b0100, crm: 4'b0000, op2: 3'b001};

endpackage

// File: rtl/retaddr_decode.sv
// Module: retaddr_decode
// Purely combinational resolver. Maps one access (encoding, level, nested
// control, host mode, direction, armed lock) to a result code and a storage
// target. Assumes lock_armed already combines feature, enable, halt and bit.
module retaddr_decode
    import retaddr_rt_pkg::*;
(
    input  sysenc_t    enc,
    input  logic [1:0] level,
    input  logic [2:0] nv,
    input  logic       host,
    input  logic       write,
    input  logic       lock_armed,
    output rsp_code_e  code,
    output tgt_e       tgt
);

    logic hit_high;
    logic hit_low;
    logic lock_now;
    rsp_code_e reg_code;

    assign hit_high = (enc == ENC_HIGH);
    assign hit_low  = (enc == ENC_LOW);
    assign lock_now = lock_armed & write;
    assign reg_code = write ? RSP_WDONE : RSP_RDATA;

    // Resolve the outcome in priority order for the current level.
    always_comb begin
        code = RSP_UNDEF;
        tgt  = TGT_NONE;
        if (hit_high || hit_low) begin
            unique case (level)
                2'd0: code = RSP_UNDEF;
                2'd1: begin
                    if (hit_high) begin
                        if (lock_now && nv[0])       code = RSP_LOCK;
                        else if (nv[2] && nv[0])     begin code = reg_code; tgt = TGT_LOW; end
                        else if (nv[0])              code = RSP_TRAP;
                        else                         code = RSP_UNDEF;
                    end else begin
                        if (lock_now && !(nv[1] && nv[0])) code = RSP_LOCK;
                        else if (nv == 3'b011)       code = RSP_TRAP;
                        else if (nv == 3'b111)       code = RSP_MEMFWD;
                        else                         begin code = reg_code; tgt = TGT_LOW; end
                    end
                end
                2'd2: begin
                    if (hit_high || host) begin
                        if (lock_now) code = RSP_LOCK;
                        else          begin code = reg_code; tgt = TGT_HIGH; end
                    end else begin
                        code = reg_code;
                        tgt  = TGT_LOW;
                    end
                end
                default: begin
                    code = reg_code;
                    tgt  = hit_high ? TGT_HIGH : TGT_LOW;
                end
            endcase
        end
    end

endmodule

// File: rtl/retaddr_regbank.sv
// Module: retaddr_regbank
// Holds the low and high return-address registers. Update priority per
// register: exception-entry load, then narrow-entry adjust (high only), then
// ordinary write. Assumes no reset value is required (contents unspecified).
module retaddr_regbank #(
    parameter int XLEN        = 64,
    parameter bit UPPER_CLEAR = 1'b1
) (
    input  logic            clk,
    input  logic            wr_low,
    input  logic            wr_high,
    input  logic [XLEN-1:0] wdata,
    input  logic            load_low,
    input  logic            load_high,
    input  logic [XLEN-1:0] load_addr,
    input  logic            narrow_entry,
    output logic [XLEN-1:0] low_q,
    output logic [XLEN-1:0] high_q
);

    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] high_narrow;

    // Pick the upper-half behaviour of the narrow entry event.
    generate
        if (UPPER_CLEAR) begin : g_clear
            assign high_narrow = {{(XLEN-HALF){1'b0}}, high_q[HALF-1:0]};
        end else begin : g_keep
            assign high_narrow = high_q;
        end
    endgenerate

    // Low register update: exception load beats write.
    always_ff @(posedge clk) begin
        if (load_low)      low_q <= load_addr;
        else if (wr_low)   low_q <= wdata;
    end

    // High register update: exception load, then narrow adjust, then write.
    always_ff @(posedge clk) begin
        if (load_high)         high_q <= load_addr;
        else if (narrow_entry) high_q <= high_narrow;
        else if (wr_high)      high_q <= wdata;
    end

endmodule

// File: rtl/retaddr_access_router.sv
// Module: retaddr_access_router (top)
// Accepts one access per cycle, resolves it and registers a single result.
// Assumes requests need no back-pressure and that results are consumed the
// cycle they are valid.
module retaddr_access_router
    import retaddr_rt_pkg::*;
#(
    parameter int          XLEN        = 64,
    parameter int          OFF_W       = 12,
    parameter logic [11:0] MEM_OFFSET  = 12'h230,
    parameter int          SYN_W       = 6,
    parameter logic [5:0]  TRAP_SYN    = 6'h18,
    parameter bit          UPPER_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_op0,
    input  logic [2:0]       req_op1,
    input  logic [3:0]       req_crn,
    input  logic [3:0]       req_crm,
    input  logic [2:0]       req_op2,
    input  logic [1:0]       req_level,
    input  logic [2:0]       req_nv,
    input  logic             req_host,
    input  logic [XLEN-1:0]  req_wdata,
    input  logic             lock_feat,
    input  logic             lock_en,
    input  logic             core_halted,
    input  logic             lock_bit,
    input  logic             exc_valid,
    input  logic             exc_to_high,
    input  logic [XLEN-1:0]  exc_addr,
    input  logic             narrow_entry,
    output logic             rsp_valid,
    output logic [2:0]       rsp_code,
    output logic [XLEN-1:0]  rsp_rdata,
    output logic [OFF_W-1:0] rsp_mem_offset,
    output logic             rsp_mem_write,
    output logic [SYN_W-1:0] rsp_syndrome
);

    sysenc_t         enc;
    rsp_code_e       dec_code;
    tgt_e            dec_tgt;
    logic            lock_armed;
    logic            wr_low;
    logic            wr_high;
    logic            is_write_done;
    logic [XLEN-1:0] low_q;
    logic [XLEN-1:0] high_q;
    logic [XLEN-1:0] sel_data;

    assign enc        = '{op0: req_op0, op1: req_op1, crn: req_crn, crm: req_crm, op2: req_op2};
    assign lock_armed = lock_feat & lock_en & ~core_halted & lock_bit;

    retaddr_decode u_decode (
        .enc        (enc),
        .level      (req_level),
        .nv         (req_nv),
        .host       (req_host),
        .write      (req_write),
        .lock_armed (lock_armed),
        .code       (dec_code),
        .tgt        (dec_tgt)
    );

    assign is_write_done = req_valid && (dec_code == RSP_WDONE);
    assign wr_low        = is_write_done && (dec_tgt == TGT_LOW);
    assign wr_high       = is_write_done && (dec_tgt == TGT_HIGH);

    retaddr_regbank #(
        .XLEN        (XLEN),
        .UPPER_CLEAR (UPPER_CLEAR)
    ) u_bank (
        .clk          (clk),
        .wr_low       (wr_low),
        .wr_high      (wr_high),
        .wdata        (req_wdata),
        .load_low     (exc_valid && !exc_to_high),
        .load_high    (exc_valid && exc_to_high),
        .load_addr    (exc_addr),
        .narrow_entry (narrow_entry),
        .low_q        (low_q),
        .high_q       (high_q)
    );

    // Read data source for the resolved target; zero when nothing is read.
    always_comb begin
        sel_data = '0;
        if (dec_code == RSP_RDATA) begin
            if (dec_tgt == TGT_LOW)       sel_data = low_q;
            else if (dec_tgt == TGT_HIGH) sel_data = high_q;
        end
    end

    // Register exactly one result per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_code       <= RSP_UNDEF;
            rsp_rdata      <= '0;
            rsp_mem_offset <= '0;
            rsp_mem_write  <= 1'b0;
            rsp_syndrome   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_code       <= dec_code;
                rsp_rdata      <= sel_data;
                rsp_mem_offset <= (dec_code == RSP_MEMFWD) ? MEM_OFFSET[OFF_W-1:0] : '0;
                rsp_mem_write  <= (dec_code == RSP_MEMFWD) && req_write;
                rsp_syndrome   <= (dec_code == RSP_TRAP) ? TRAP_SYN[SYN_W-1:0] : '0;
            end
        end
    end

endmodule

// File: rtl/retaddr_access_router_chk.sv
// Module: retaddr_access_router_chk
// Property checker bound into the router top. Observes ports and the two
// stored registers; assumes the default 64-bit layout of the package.
module retaddr_access_router_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_write,
    input logic [1:0]      req_op0,
    input logic [2:0]      req_op1,
    input logic [3:0]      req_crn,
    input logic [3:0]      req_crm,
    input logic [2:0]      req_op2,
    input logic [1:0]      req_level,
    input logic            lock_feat,
    input logic            lock_en,
    input logic            core_halted,
    input logic            lock_bit,
    input logic            exc_valid,
    input logic            exc_to_high,
    input logic [XLEN-1:0] exc_addr,
    input logic            narrow_entry,
    input logic            rsp_valid,
    input logic [2:0]      rsp_code,
    input logic [XLEN-1:0] low_q,
    input logic [XLEN-1:0] high_q
);

    logic sees_high;
    logic sees_low;
    logic armed;

    assign sees_high = (req_op0 == 2'b11) && (req_op1 == 3'b100) && (req_crn == 4'b0100)
                     && (req_crm == 4'b0000) && (req_op2 == 3'b001);
    assign sees_low  = (req_op0 == 2'b11) && (req_op1 == 3'b000) && (req_crn == 4'b0100)
                     && (req_crm == 4'b0000) && (req_op2 == 3'b001);
    assign armed     = lock_feat && lock_en && !core_halted && lock_bit;

    a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r2_level0_undef: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_level == 2'd0) |=> rsp_code == 3'd3);
    a_r7_lock_level2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && armed && (req_level == 2'd2) && sees_high |=> rsp_code == 3'd5);
    a_r5_level3_reaches: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_level == 2'd3) && (sees_high || sees_low) |=> rsp_code inside {3'd0, 3'd1});
    a_r9_load_low: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid && !exc_to_high |=> low_q == $past(exc_addr));
    a_r9_load_high: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid && exc_to_high |=> high_q == $past(exc_addr));
    a_r1_unknown_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !sees_high && !sees_low && !exc_valid && !narrow_entry
        |=> $stable(low_q) && $stable(high_q));

endmodule

bind retaddr_access_router retaddr_access_router_chk #(.XLEN(XLEN)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_op0      (req_op0),
    .req_op1      (req_op1),
    .req_crn      (req_crn),
    .req_crm      (req_crm),
    .req_op2      (req_op2),
    .req_level    (req_level),
    .lock_feat    (lock_feat),
    .lock_en      (lock_en),
    .core_halted  (core_halted),
    .lock_bit     (lock_bit),
    .exc_valid    (exc_valid),
    .exc_to_high  (exc_to_high),
    .exc_addr     (exc_addr),
    .narrow_entry (narrow_entry),
    .rsp_valid    (rsp_valid),
    .rsp_code     (rsp_code),
    .low_q        (low_q),
    .high_q       (high_q)
);

// File: tb/retaddr_access_router_tb_top.sv
// Bench: vector table for routing, then directed cases for reset, storage
// collisions, narrow entry and lock gating.
module retaddr_access_router_tb_top;

    localparam bit TB_CLEAR = 1'b1;
    // Vector layout: {level[14:13], enc[12:11], nv[10:8], host[7], wr[6], lock[5], code[4:2], tgt[1:0]}
    // enc: 0 low accessor, 1 high accessor, 2 unknown. tgt: 0 none, 1 low, 2 high.
    localparam int NV = 27;
    localparam logic [14:0] VEC [NV] = '{
        {2'd0, 2'd1, 3'b000, 1'b0, 1'b0, 1'b0, 3'd3, 2'd0},  // R2
        {2'd0, 2'd0, 3'b000, 1'b0, 1'b1, 1'b0, 3'd3, 2'd0},  // R2
        {2'd1, 2'd1, 3'b101, 1'b0, 1'b0, 1'b0, 3'd0, 2'd1},  // R3
        {2'd1, 2'd1, 3'b111, 1'b0, 1'b1, 1'b0, 3'd1, 2'd1},  // R3
        {2'd1, 2'd1, 3'b001, 1'b0, 1'b0, 1'b0, 3'd4, 2'd0},  // R3
        {2'd1, 2'd1, 3'b100, 1'b0, 1'b0, 1'b0, 3'd3, 2'd0},  // R3
        {2'd1, 2'd0, 3'b011, 1'b0, 1'b0, 1'b0, 3'd4, 2'd0},  // R4
        {2'd1, 2'd0, 3'b111, 1'b0, 1'b1, 1'b0, 3'd2, 2'd0},  // R4
        {2'd1, 2'd0, 3'b111, 1'b0, 1'b0, 1'b0, 3'd2, 2'd0},  // R4
        {2'd1, 2'd0, 3'b101, 1'b0, 1'b1, 1'b0, 3'd1, 2'd1},  // R4
        {2'd1, 2'd0, 3'b000, 1'b0, 1'b0, 1'b0, 3'd0, 2'd1},  // R4 R8
        {2'd2, 2'd1, 3'b000, 1'b0, 1'b1, 1'b0, 3'd1, 2'd2},  // R5
        {2'd3, 2'd1, 3'b111, 1'b1, 1'b0, 1'b0, 3'd0, 2'd2},  // R5 R8
        {2'd2, 2'd0, 3'b000, 1'b1, 1'b0, 1'b0, 3'd0, 2'd2},  // R6
        {2'd2, 2'd0, 3'b000, 1'b0, 1'b1, 1'b0, 3'd1, 2'd1},  // R6
        {2'd3, 2'd0, 3'b000, 1'b1, 1'b1, 1'b0, 3'd1, 2'd1},  // R6
        {2'd2, 2'd1, 3'b000, 1'b0, 1'b1, 1'b1, 3'd5, 2'd0},  // R7
        {2'd2, 2'd1, 3'b000, 1'b0, 1'b0, 1'b1, 3'd0, 2'd2},  // R7 read not locked
        {2'd2, 2'd0, 3'b000, 1'b1, 1'b1, 1'b1, 3'd5, 2'd0},  // R7
        {2'd2, 2'd0, 3'b000, 1'b0, 1'b1, 1'b1, 3'd1, 2'd1},  // R7
        {2'd1, 2'd1, 3'b001, 1'b0, 1'b1, 1'b1, 3'd5, 2'd0},  // R7
        {2'd1, 2'd1, 3'b100, 1'b0, 1'b1, 1'b1, 3'd3, 2'd0},  // R7
        {2'd1, 2'd0, 3'b011, 1'b0, 1'b1, 1'b1, 3'd4, 2'd0},  // R7
        {2'd1, 2'd0, 3'b000, 1'b0, 1'b1, 1'b1, 3'd5, 2'd0},  // R7
        {2'd3, 2'd1, 3'b000, 1'b0, 1'b1, 1'b1, 3'd1, 2'd2},  // R7
        {2'd2, 2'd2, 3'b000, 1'b0, 1'b0, 1'b0, 3'd3, 2'd0},  // R1
        {2'd3, 2'd2, 3'b000, 1'b0, 1'b1, 1'b0, 3'd3, 2'd0}   // R1
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_host;
    logic [1:0]  req_op0, req_level;
    logic [2:0]  req_op1, req_op2, req_nv;
    logic [3:0]  req_crn, req_crm;
    logic [63:0] req_wdata, exc_addr;
    logic        lock_feat, lock_en, core_halted, lock_bit;
    logic        exc_valid, exc_to_high, narrow_entry;
    logic        rsp_valid, rsp_mem_write;
    logic [2:0]  rsp_code;
    logic [63:0] rsp_rdata;
    logic [11:0] rsp_mem_offset;
    logic [5:0]  rsp_syndrome;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    logic [63:0] m_low, m_high;

    always #4 clk = ~clk;

    retaddr_access_router #(.UPPER_CLEAR(TB_CLEAR)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .req_level(req_level), .req_nv(req_nv), .req_host(req_host),
        .req_wdata(req_wdata), .lock_feat(lock_feat), .lock_en(lock_en),
        .core_halted(core_halted), .lock_bit(lock_bit), .exc_valid(exc_valid),
        .exc_to_high(exc_to_high), .exc_addr(exc_addr), .narrow_entry(narrow_entry),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
        .rsp_mem_offset(rsp_mem_offset), .rsp_mem_write(rsp_mem_write),
        .rsp_syndrome(rsp_syndrome)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge; return at the next falling edge.
    task automatic send(input logic [1:0] lvl, input logic [1:0] enc, input logic [2:0] nv,
                        input logic host, input logic wr, input logic lock, input logic halted,
                        input logic [63:0] d);
        req_valid   = 1'b1;
        req_write   = wr;
        req_op0     = 2'b11;
        req_op1     = (enc == 2'd1) ? 3'b100 : 3'b000;
        req_crn     = 4'b0100;
        req_crm     = 4'b0000;
        req_op2     = (enc == 2'd2) ? 3'b010 : 3'b001;
        req_level   = lvl;
        req_nv      = nv;
        req_host    = host;
        req_wdata   = d;
        lock_feat   = lock;
        lock_en     = lock;
        lock_bit    = lock;
        core_halted = halted;
        @(posedge clk);
        @(negedge clk);
        req_valid   = 1'b0;
        exc_valid   = 1'b0;
        narrow_entry = 1'b0;
    endtask

    initial begin
        req_valid = 0; req_write = 0; req_op0 = 0; req_op1 = 0; req_crn = 0; req_crm = 0;
        req_op2 = 0; req_level = 0; req_nv = 0; req_host = 0; req_wdata = 0;
        lock_feat = 0; lock_en = 0; core_halted = 0; lock_bit = 0;
        exc_valid = 0; exc_to_high = 0; exc_addr = 0; narrow_entry = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R11 reset valid", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R11 idle valid", {63'd0, rsp_valid}, 64'd0);

        // Give both registers known contents through level-3 writes.
        m_low  = 64'h1111_2222_3333_4444;
        m_high = 64'h5555_6666_7777_8888;
        send(2'd3, 2'd0, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, m_low);
        check(rsp_code == 3'd1, "R8 write done", {61'd0, rsp_code}, 64'd1);
        send(2'd3, 2'd1, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, m_high);
        send(2'd3, 2'd1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 64'd0);
        check(rsp_rdata == m_high, "R8 readback high", rsp_rdata, m_high);

        for (int i = 0; i < NV; i++) begin
            logic [63:0] d;
            logic [2:0]  ec;
            logic [1:0]  et;
            d  = 64'hA5A5_0000_0000_0000 + 64'(i) * 64'h1111;
            ec = VEC[i][4:2];
            et = VEC[i][1:0];
            send(VEC[i][14:13], VEC[i][12:11], VEC[i][10:8], VEC[i][7], VEC[i][6], VEC[i][5], 1'b0, d);
            check(rsp_valid == 1'b1, $sformatf("R11 vec %0d valid", i), {63'd0, rsp_valid}, 64'd1);
            check(rsp_code == ec, $sformatf("R1-route vec %0d code", i), {61'd0, rsp_code}, {61'd0, ec});
            if (ec == 3'd0)
                check(rsp_rdata == ((et == 2'd1) ? m_low : m_high), $sformatf("R8 vec %0d rdata", i),
                      rsp_rdata, (et == 2'd1) ? m_low : m_high);
            if (ec == 3'd1) begin
                if (et == 2'd1) m_low = d;
                else            m_high = d;
            end
            if (ec == 3'd2) begin
                check(rsp_mem_offset == 12'h230, $sformatf("R4 vec %0d offset", i), {52'd0, rsp_mem_offset}, 64'h230);
                check(rsp_mem_write == VEC[i][6], $sformatf("R4 vec %0d dir", i), {63'd0, rsp_mem_write}, {63'd0, VEC[i][6]});
            end
            if (ec == 3'd4)
                check(rsp_syndrome == 6'h18, $sformatf("R3 vec %0d syndrome", i), {58'd0, rsp_syndrome}, 64'h18);
        end

        // R1: the unknown-encoding write must not have touched either register.
        send(2'd3, 2'd0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 64'd0);
        check(rsp_rdata == m_low, "R1 low unchanged", rsp_rdata, m_low);
        send(2'd3, 2'd1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 64'd0);
        check(rsp_rdata == m_high, "R1 high unchanged", rsp_rdata, m_high);

        // R9: plain exception load into the low register.
        exc_valid = 1'b1; exc_to_high = 1'b0; exc_addr = 64'h0BAD_F00D_0000_0040;
        @(negedge clk);
        exc_valid = 1'b0;
        send(2'd3, 2'd0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 64'd0);
        check(rsp_rdata == 64'h0BAD_F00D_0000_0040, "R9 load low", rsp_rdata, 64'h0BAD_F00D_0000_0040);

        // R9: load and write hit the high register in the same cycle; load wins.
        exc_valid = 1'b1; exc_to_high = 1'b1; exc_addr = 64'hFEED_0000_0000_1000;
        send(2'd2, 2'd1, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0123_4567_89AB_CDEF);
        send(2'd3, 2'd1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 64'd0);
        check(rsp_rdata == 64'hFEED_0000_0000_1000, "R9 collision", rsp_rdata, 64'hFEED_0000_0000_1000);

        // R10: narrow entry adjusts the upper half of the high register.
        send(2'd3, 2'd1, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 64'hDEAD_BEEF_1234_5678);
        narrow_entry = 1'b1;
        @(negedge clk);
        narrow_entry = 1'b0;
        send(2'd3, 2'd1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 64'd0);
        check(rsp_rdata == (TB_CLEAR ? 64'h0000_0000_1234_5678 : 64'hDEAD_BEEF_1234_5678),
              "R10 narrow entry", rsp_rdata,
              TB_CLEAR ? 64'h0000_0000_1234_5678 : 64'hDEAD_BEEF_1234_5678);

        // R7: halted core disarms the lock; write goes through.
        send(2'd2, 2'd1, 3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 64'h7777_0000_0000_0007);
        check(rsp_code == 3'd1, "R7 halted no lock", {61'd0, rsp_code}, 64'd1);
        send(2'd2, 2'd1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 64'd0);
        check(rsp_rdata == 64'h7777_0000_0000_0007, "R8 next-cycle read", rsp_rdata, 64'h7777_0000_0000_0007);

        @(negedge clk);
        check(rsp_valid == 1'b0, "R11 quiet after request", {63'd0, rsp_valid}, 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule